// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

This block turns 32-bit virtual addresses into physical addresses. The virtual address is split into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. Translated pages are held in a small fully associative translation cache. A cache miss starts a two-step walk over a single-request memory port. The first read fetches the directory entry and the second fetches the table entry.

The walk checks the present bit at each level. On the final entry it also checks the writable bit. A failure is reported as a read fault or a write fault, matching the kind of request, and the faulting virtual address is latched. When translation is off, addresses pass through unchanged.

Software controls the cache in two ways. Loading a new directory base empties the whole cache. A single page can also be evicted by its virtual address.

Top module: `pgwalk_xlat`

## Requirements
- R1: With `xlat_en` low, an accepted request returns `rsp_paddr` equal to the virtual address, with no fault, one cycle after acceptance and without any memory read.
- R2: On a miss, the first memory read is at `{base[31:12], va[31:22], 2'b00}` and the second is at `{dir_entry[31:12], va[21:12], 2'b00}`. A successful result is `{tbl_entry[31:12], va[11:0]}`.
- R3: If bit 0 (present) of the directory entry is 0, the walk stops after one read. The response raises `rsp_fault_rd` for a read request and `rsp_fault_wr` for a write request (`req_write`=1).
- R4: If bit 0 of the table entry is 0, the response faults with the same read/write kind rule, and the page is not cached.
- R5: If bit 1 (writable) of the table entry is 0, a write request raises `rsp_fault_wr` and a read request succeeds. This also applies when the entry comes from the cache.
- R6: A cache hit responds one cycle after acceptance with no memory read. During a walk, `req_ready` is low.
- R7: The cache holds 4 entries, refilled in round-robin order. The fifth distinct page evicts the oldest filled slot.
- R8: A `dir_load` pulse stores the new base from `dir_base[31:12]` and invalidates every cached page.
- R9: A `flush_page` pulse invalidates only the cached page whose number equals `flush_vaddr[31:12]`.
- R10: In a cycle with `flush_page` or `dir_load` high, `req_ready` is low, so a request waiting in that cycle looks up the flushed cache. A flush that arrives during a walk stops that walk's result from being cached.
- R11: `fault_vaddr` captures the virtual address of each faulting request. It holds that value through later non-faulting responses.
- R12: After reset, `req_ready` is 1, and `rsp_valid`, `mem_req` and `fault_vaddr` are 0. The cache is empty and the base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable |
| dir_load | input | 1 | Load new directory base and flush all |
| dir_base | input | 32 | New directory base (bits 31:12 used) |
| flush_page | input | 1 | Invalidate one cached page |
| flush_vaddr | input | 32 | Address of the page to invalidate |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault_rd | output | 1 | Read page fault |
| rsp_fault_wr | output | 1 | Write page fault |
| fault_vaddr | output | 32 | Virtual address of the latest fault |
| mem_req | output | 1 | Memory read request, held until mem_rvalid |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Two functions can land in the same cycle: a cache invalidation and a cache lookup (or a walk fill). The bench raises `flush_page` in the same cycle as a request for the page being flushed. It checks that `req_ready` is low in that cycle and that the request, once taken, walks memory again. Separately, it pulses a flush while a slowed walk is in progress, then asks for the walked page again and expects a second walk rather than a hit. All results are compared with a bench-side walk function and a round-robin cache model.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W     = 32;
  localparam int OFS_W    = 12;
  localparam int IDX_W    = 10;
  localparam int VPN_W    = VA_W - OFS_W;
  localparam int ENT_SH   = 2;
  localparam int PRES_BIT = 0;
  localparam int WRT_BIT  = 1;

  typedef logic [VPN_W-1:0] vpn_t;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_DIR  = 2'd1,
    WK_TBL  = 2'd2
  } wk_state_t;
endpackage

// File: rtl/pgwalk_tcache.sv
module pgwalk_tcache
  import pgwalk_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic clk,
  input  logic rst,
  input  vpn_t look_vpn,
  output logic look_hit,
  output vpn_t look_frame,
  output logic look_wr,
  input  logic flush_all,
  input  logic flush_one,
  input  vpn_t flush_vpn,
  input  logic fill_en,
  input  vpn_t fill_vpn,
  input  vpn_t fill_frame,
  input  logic fill_wr
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] wr_q;
  vpn_t               tag_q [ENTRIES];
  vpn_t               frm_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;
  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == look_vpn);
    end
  endgenerate

  always_comb begin
    look_hit   = |match;
    look_frame = '0;
    look_wr    = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        look_frame = look_frame | frm_q[i];
        look_wr    = look_wr | wr_q[i];
      end
    end
  end

  // payload storage: no reset, written only on fill
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[rr_q] <= fill_vpn;
      frm_q[rr_q] <= fill_frame;
      wr_q[rr_q]  <= fill_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      if (fill_en) begin
        vld_q[rr_q] <= 1'b1;
        rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all || (flush_one && tag_q[i] == flush_vpn)) vld_q[i] <= 1'b0;
      end
    end
  end

  // R7: a page is never cached twice
  a_r7_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
  // R8: full flush leaves nothing valid
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (vld_q == '0));
endmodule

// File: rtl/pgwalk_walk.sv
module pgwalk_walk
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VA_W-1:0] start_va,
  input  vpn_t            dir_frame,
  input  logic            mem_rvalid,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  output logic            busy,
  output logic            done,
  output logic            done_present,
  output logic            done_wr,
  output vpn_t            done_frame
);
  localparam int TBL_LO = OFS_W;
  localparam int TBL_HI = OFS_W + IDX_W - 1;

  wk_state_t       st_q;
  logic [VA_W-1:0] va_q;
  logic [VA_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= WK_IDLE;
      va_q   <= '0;
      addr_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (start) begin
          st_q   <= WK_DIR;
          va_q   <= start_va;
          addr_q <= {dir_frame, start_va[VA_W-1 -: IDX_W], {ENT_SH{1'b0}}};
        end
        WK_DIR: if (mem_rvalid) begin
          if (mem_rdata[PRES_BIT]) begin
            st_q   <= WK_TBL;
            addr_q <= {mem_rdata[VA_W-1:OFS_W], va_q[TBL_HI:TBL_LO], {ENT_SH{1'b0}}};
          end else begin
            st_q <= WK_IDLE;
          end
        end
        WK_TBL: if (mem_rvalid) st_q <= WK_IDLE;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != WK_IDLE);
  assign mem_req      = busy;
  assign mem_addr     = addr_q;
  assign done         = mem_rvalid && ((st_q == WK_DIR && !mem_rdata[PRES_BIT]) || st_q == WK_TBL);
  assign done_present = (st_q == WK_TBL) && mem_rdata[PRES_BIT];
  assign done_wr      = mem_rdata[WRT_BIT];
  assign done_frame   = mem_rdata[VA_W-1:OFS_W];

  // R2: address held steady until data returns
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R3: absent directory entry ends the walk
  a_r3_dir_abort: assert property (@(posedge clk) disable iff (rst)
    (st_q == WK_DIR && mem_rvalid && !mem_rdata[PRES_BIT]) |=> !mem_req);
endmodule

// File: rtl/pgwalk_xlat.sv
module pgwalk_xlat
  import pgwalk_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xlat_en,
  input  logic            dir_load,
  input  logic [VA_W-1:0] dir_base,
  input  logic            flush_page,
  input  logic [VA_W-1:0] flush_vaddr,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_fault_rd,
  output logic            rsp_fault_wr,
  output logic [VA_W-1:0] fault_vaddr,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [VA_W-1:0] mem_rdata
);
  logic            flush_any, accept, walk_start, fill_en;
  logic            c_hit, c_wr;
  vpn_t            c_frame;
  logic            w_busy, w_done, w_present, w_wr;
  vpn_t            w_frame;
  vpn_t            dir_frame_q;
  logic            kill_q, wr_q;
  logic [VA_W-1:0] va_q;

  assign flush_any  = dir_load || flush_page;
  assign req_ready  = !w_busy && !flush_any;
  assign accept     = req_valid && req_ready;
  assign walk_start = accept && xlat_en && !c_hit;
  assign fill_en    = w_done && w_present && !kill_q && !flush_any;

  pgwalk_tcache #(.ENTRIES(ENTRIES)) u_cache (
    .clk        (clk),
    .rst        (rst),
    .look_vpn   (req_vaddr[VA_W-1:OFS_W]),
    .look_hit   (c_hit),
    .look_frame (c_frame),
    .look_wr    (c_wr),
    .flush_all  (dir_load),
    .flush_one  (flush_page),
    .flush_vpn  (flush_vaddr[VA_W-1:OFS_W]),
    .fill_en    (fill_en),
    .fill_vpn   (va_q[VA_W-1:OFS_W]),
    .fill_frame (w_frame),
    .fill_wr    (w_wr)
  );

  pgwalk_walk u_walk (
    .clk          (clk),
    .rst          (rst),
    .start        (walk_start),
    .start_va     (req_vaddr),
    .dir_frame    (dir_frame_q),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .busy         (w_busy),
    .done         (w_done),
    .done_present (w_present),
    .done_wr      (w_wr),
    .done_frame   (w_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_fault_rd <= 1'b0;
      rsp_fault_wr <= 1'b0;
      fault_vaddr  <= '0;
      dir_frame_q  <= '0;
      kill_q       <= 1'b0;
      wr_q         <= 1'b0;
      va_q         <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_fault_rd <= 1'b0;
      rsp_fault_wr <= 1'b0;
      if (dir_load) dir_frame_q <= dir_base[VA_W-1:OFS_W];
      if (walk_start) begin
        wr_q   <= req_write;
        va_q   <= req_vaddr;
        kill_q <= 1'b0;
      end else if (w_busy && flush_any) begin
        kill_q <= 1'b1;
      end
      if (accept && !xlat_en) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= req_vaddr;
      end else if (accept && c_hit) begin
        rsp_valid <= 1'b1;
        if (req_write && !c_wr) begin
          rsp_fault_wr <= 1'b1;
          rsp_paddr    <= '0;
          fault_vaddr  <= req_vaddr;
        end else begin
          rsp_paddr <= {c_frame, req_vaddr[OFS_W-1:0]};
        end
      end else if (w_done) begin
        rsp_valid <= 1'b1;
        if (!w_present) begin
          rsp_fault_rd <= !wr_q;
          rsp_fault_wr <= wr_q;
          rsp_paddr    <= '0;
          fault_vaddr  <= va_q;
        end else if (wr_q && !w_wr) begin
          rsp_fault_wr <= 1'b1;
          rsp_paddr    <= '0;
          fault_vaddr  <= va_q;
        end else begin
          rsp_paddr <= {w_frame, va_q[OFS_W-1:0]};
        end
      end
    end
  end

  // R1: bypass answers next cycle with the same address
  a_r1_bypass: assert property (@(posedge clk) disable iff (rst)
    (accept && !xlat_en) |=> (rsp_valid && rsp_paddr == $past(req_vaddr)
                              && !rsp_fault_rd && !rsp_fault_wr));
  // R6: a hit never touches memory
  a_r6_hit_no_walk: assert property (@(posedge clk) disable iff (rst)
    (accept && xlat_en && c_hit) |=> (rsp_valid && !mem_req));
  // R3: a fault has exactly one kind
  a_r3_one_kind: assert property (@(posedge clk) disable iff (rst)
    !(rsp_fault_rd && rsp_fault_wr));
  // R11: fault address moves only with a fault response
  a_r11_fault_hold: assert property (@(posedge clk) disable iff (rst)
    !(rsp_fault_rd || rsp_fault_wr) |-> (fault_vaddr == $past(fault_vaddr) || $past(rst)));
endmodule

// File: tb/pgwalk_xlat_test.sv
module pgwalk_xlat_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xlat_en = 1'b0, dir_load = 1'b0, flush_page = 1'b0;
  logic [31:0] dir_base = '0, flush_vaddr = '0, req_vaddr = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault_rd, rsp_fault_wr, mem_req;
  logic [31:0] rsp_paddr, fault_vaddr, mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  always #5 clk = ~clk;

  pgwalk_xlat #(.ENTRIES(4)) uut (
    .clk(clk), .rst(rst), .xlat_en(xlat_en), .dir_load(dir_load), .dir_base(dir_base),
    .flush_page(flush_page), .flush_vaddr(flush_vaddr), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault_rd(rsp_fault_rd),
    .rsp_fault_wr(rsp_fault_wr), .fault_vaddr(fault_vaddr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int          n_chk = 0, n_bad = 0;
  int          mem_lat = 0, wait_cnt = 0, nreads = 0;
  logic [31:0] addr_log [4];
  bit          m_vld [4];
  bit          m_wr [4];
  logic [19:0] m_vpn [4];
  logic [19:0] m_frm [4];
  int          m_ptr = 0;
  logic [19:0] m_base = '0;
  logic [19:0] pool [8];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    h = (a ^ (a >> 13)) * 32'h2545F491;
    h = h ^ (h >> 9);
    return {h[31:12], 10'd0, h[4], h[2] | h[3]};
  endfunction

  // kind 0: walk ok & writable, 1: dir absent, 2: table absent, 3: read-only
  function automatic logic [19:0] find_kind(input logic [19:0] from, input int kind);
    logic [31:0] pde, pte;
    logic [19:0] v;
    for (int i = 0; i < 4096; i++) begin
      v   = from + 20'(i);
      pde = mem_word({m_base, v[19:10], 2'b00});
      pte = mem_word({pde[31:12], v[9:0], 2'b00});
      if (kind == 1 && !pde[0]) return v;
      if (pde[0]) begin
        if (kind == 2 && !pte[0]) return v;
        if (kind == 0 && pte[0] && pte[1]) return v;
        if (kind == 3 && pte[0] && !pte[1]) return v;
      end
    end
    return from;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // memory model: one word per request, programmable latency
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_req) begin
        if (wait_cnt < mem_lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          mem_rvalid = 1'b1;
          mem_rdata = mem_word(mem_addr);
          addr_log[nreads % 4] = mem_addr;
          nreads++;
        end
      end
    end
  end

  task automatic model_flush(input logic [19:0] v);
    for (int i = 0; i < 4; i++) if (m_vpn[i] == v) m_vld[i] = 0;
  endtask

  task automatic do_flush(input logic [31:0] va);
    @(negedge clk);
    flush_page = 1'b1; flush_vaddr = va;
    @(negedge clk);
    flush_page = 1'b0;
    model_flush(va[31:12]);
  endtask

  task automatic do_load(input logic [31:0] b);
    @(negedge clk);
    dir_load = 1'b1; dir_base = b;
    @(negedge clk);
    dir_load = 1'b0;
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
    m_base = b[31:12];
  endtask

  task automatic do_req(input logic [31:0] va, input bit wr, input bit en,
                        input bit mid, input logic [31:0] mva);
    logic [31:0] epa, a0, a1, pde, pte;
    bit efr, efw, hit, fill, fw;
    int enr, lat, r0, slot;
    logic [19:0] ffr;
    string ftag;
    epa = '0; efr = 0; efw = 0; hit = 0; fill = 0; fw = 0; enr = 0; slot = 0;
    a0 = '0; a1 = '0; ffr = '0; ftag = "R2";
    if (!en) epa = va;
    else begin
      for (int i = 0; i < 4; i++) if (m_vld[i] && m_vpn[i] == va[31:12]) begin hit = 1; slot = i; end
      if (hit) begin
        ftag = "R5";
        if (wr && !m_wr[slot]) efw = 1; else epa = {m_frm[slot], va[11:0]};
      end else begin
        a0 = {m_base, va[31:22], 2'b00}; pde = mem_word(a0); enr = 1;
        if (!pde[0]) begin efr = !wr; efw = wr; ftag = "R3"; end
        else begin
          a1 = {pde[31:12], va[21:12], 2'b00}; pte = mem_word(a1); enr = 2;
          if (!pte[0]) begin efr = !wr; efw = wr; ftag = "R4"; end
          else begin
            fill = !mid; ffr = pte[31:12]; fw = pte[1]; ftag = "R5";
            if (wr && !pte[1]) efw = 1; else epa = {pte[31:12], va[11:0]};
          end
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; xlat_en = en; r0 = nreads;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (mid) begin
      flush_page = 1'b1; flush_vaddr = mva;
      @(negedge clk);
      flush_page = 1'b0; lat++;
      model_flush(mva[31:12]);
    end
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    chk(rsp_valid, "R6", "response seen", 32'(rsp_valid), 32'd1);
    if (!en) begin
      chk(rsp_paddr == va && !rsp_fault_rd && !rsp_fault_wr, "R1", "bypass address", rsp_paddr, va);
      chk(lat == 1 && nreads == r0, "R1", "bypass latency", 32'(lat), 32'd1);
    end else begin
      chk(rsp_fault_rd == efr && rsp_fault_wr == efw, ftag, "fault bits",
          {30'd0, rsp_fault_rd, rsp_fault_wr}, {30'd0, efr, efw});
      if (!efr && !efw) chk(rsp_paddr == epa, "R2", "physical address", rsp_paddr, epa);
      else chk(fault_vaddr == va, "R11", "fault address", fault_vaddr, va);
      chk(nreads - r0 == enr, hit ? "R6" : "R2", "memory reads", 32'(nreads - r0), 32'(enr));
      if (enr >= 1) chk(addr_log[r0 % 4] == a0, "R2", "directory entry address", addr_log[r0 % 4], a0);
      if (enr == 2) chk(addr_log[(r0 + 1) % 4] == a1, "R2", "table entry address", addr_log[(r0 + 1) % 4], a1);
      if (hit) chk(lat == 1, "R6", "hit latency", 32'(lat), 32'd1);
    end
    if (fill) begin
      m_vld[m_ptr] = 1; m_vpn[m_ptr] = va[31:12]; m_frm[m_ptr] = ffr; m_wr[m_ptr] = fw;
      m_ptr = (m_ptr + 1) % 4;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected 0 hung cycles", 1);
    summary();
    $finish;
  end

  initial begin
    logic [19:0] p [5];
    logic [19:0] v, fv;
    int r0;
    void'($urandom(777));
    for (int k = 0; k < 4; k++) m_vld[k] = 0;
    for (int k = 0; k < 8; k++) pool[k] = {10'(k / 2 + 3), 10'(k * 37)};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R12", "ready after reset", 32'(req_ready), 32'd1);
    chk(!rsp_valid && !mem_req, "R12", "idle after reset", {30'd0, rsp_valid, mem_req}, 32'd0);
    chk(fault_vaddr == '0, "R12", "fault address after reset", fault_vaddr, 32'd0);

    do_req(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, '0);                 // R1
    do_req(32'h0040_1234, 1'b0, 1'b1, 1'b0, '0);                 // R12: base 0 walk
    do_load(32'h0012_3ABC);                                      // R8

    p[0] = find_kind(20'h00400, 0);
    for (int k = 1; k < 5; k++) p[k] = find_kind(p[k-1] + 20'd1, 0);
    for (int k = 0; k < 5; k++) do_req({p[k], 12'h5A4}, 1'b0, 1'b1, 1'b0, '0);
    r0 = nreads;
    do_req({p[0], 12'h010}, 1'b0, 1'b1, 1'b0, '0);
    chk(nreads - r0 == 2, "R7", "oldest page evicted", 32'(nreads - r0), 32'd2);
    r0 = nreads;
    do_req({p[2], 12'h020}, 1'b1, 1'b1, 1'b0, '0);
    chk(nreads == r0, "R7", "retained page hits", 32'(nreads - r0), 32'd0);

    do_flush({p[2], 12'h0});                                     // R9
    r0 = nreads;
    do_req({p[2], 12'h030}, 1'b0, 1'b1, 1'b0, '0);
    chk(nreads - r0 == 2, "R9", "flushed page walks", 32'(nreads - r0), 32'd2);
    r0 = nreads;
    do_req({p[3], 12'h040}, 1'b0, 1'b1, 1'b0, '0);
    chk(nreads == r0, "R9", "neighbour page kept", 32'(nreads - r0), 32'd0);

    do_load(32'h00AB_C000);                                      // R8
    r0 = nreads;
    do_req({p[3], 12'h050}, 1'b0, 1'b1, 1'b0, '0);
    chk(nreads - r0 >= 1, "R8", "cache emptied by load", 32'(nreads - r0), 32'd1);

    v = find_kind(20'h01000, 1);
    do_req({v, 12'h111}, 1'b0, 1'b1, 1'b0, '0);                  // R3 read kind
    do_req({v, 12'h222}, 1'b1, 1'b1, 1'b0, '0);                  // R3 write kind
    v = find_kind(20'h01000, 2);
    do_req({v, 12'h333}, 1'b1, 1'b1, 1'b0, '0);                  // R4
    r0 = nreads;
    do_req({v, 12'h334}, 1'b0, 1'b1, 1'b0, '0);
    chk(nreads - r0 == 2, "R4", "absent page not cached", 32'(nreads - r0), 32'd2);
    v = find_kind(20'h01000, 3);
    do_req({v, 12'h444}, 1'b1, 1'b1, 1'b0, '0);                  // R5 write on read-only
    fv = v;
    do_req({v, 12'h448}, 1'b0, 1'b1, 1'b0, '0);                  // R5 read succeeds (hit)
    do_req({v, 12'h44C}, 1'b1, 1'b1, 1'b0, '0);                  // R5 cached write fault
    v = find_kind(20'h02000, 0);
    do_req({v, 12'h555}, 1'b1, 1'b1, 1'b0, '0);
    chk(fault_vaddr == {fv, 12'h44C}, "R11", "fault address held", fault_vaddr, {fv, 12'h44C});

    // R10: flush and request for the same cached page in one cycle
    do_req({v, 12'h556}, 1'b0, 1'b1, 1'b0, '0);
    @(negedge clk);
    flush_page = 1'b1; flush_vaddr = {v, 12'h0};
    req_valid = 1'b1; req_vaddr = {v, 12'h557}; req_write = 1'b0; xlat_en = 1'b1;
    r0 = nreads;
    #1;
    chk(req_ready == 1'b0, "R10", "ready low during flush", 32'(req_ready), 32'd0);
    @(negedge clk);
    flush_page = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 100 && !rsp_valid; w++) @(negedge clk);
    chk(nreads - r0 == 2, "R10", "colliding request walks", 32'(nreads - r0), 32'd2);
    do_load(32'h0012_3000);

    // R10: flush during a walk blocks the fill
    mem_lat = 3;
    v = find_kind(20'h03000, 0);
    do_req({v, 12'h600}, 1'b0, 1'b1, 1'b1, 32'h7777_7000);
    r0 = nreads;
    do_req({v, 12'h604}, 1'b0, 1'b1, 1'b0, '0);
    chk(nreads - r0 == 2, "R10", "killed walk not cached", 32'(nreads - r0), 32'd2);

    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom_range(0, 99);
      mem_lat = $urandom_range(0, 3);
      if (sel < 4) do_load(($urandom_range(0, 1) == 1) ? 32'h0012_3000 : 32'h00AB_C000);
      else if (sel < 9) do_flush({pool[$urandom_range(0, 7)], 12'h0});
      else do_req({pool[$urandom_range(0, 7)], 12'($urandom)}, 1'($urandom_range(0, 1)),
                  $urandom_range(0, 9) != 0, 1'b0, '0);
    end

    summary();
    $finish;
  end
endmodule